// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction decode and the execution units of one streaming core. On every clock it looks at the two oldest decoded instructions of each resident warp and decides which warps may start work. A warp moves as a single unit, so the decision is made per warp and never per thread. A per-warp, per-register busy scoreboard records which registers still wait for an in-flight result. An instruction is started only when none of the registers it reads or writes is still pending.

Up to `ISSUE_SLOTS` warps are chosen per clock. The ready warps are scanned in rotating order, beginning with the warp that follows the last one granted. Each chosen warp may also start its second instruction in the same clock. This needs the second instruction to pass the scoreboard and to have no register overlap with the first. Results return through writeback ports that carry a warp and register index. The fetch stage advances a warp's instruction window when it sees that warp's grants.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset both grant vectors are zero, every scoreboard bit is clear and the rotating scan begins at warp 0.
- R2: Grants are registered. Inputs present before a rising edge produce grants that are visible after that edge. `grant_second[w]` is never set unless `grant_first[w]` is also set.
- R3: The first instruction of warp w is granted only if it is valid, neither of its two source registers is busy for warp w and, when it writes, its destination is not busy for warp w. This covers read-after-write and write-after-write.
- R4: Issuing a writing instruction sets the busy bit of its destination from the next decision on. A writeback for that warp and register clears the bit at the edge where it is presented, so a dependent instruction can be granted at the following edge.
- R5: No more than `ISSUE_SLOTS` bits of `grant_first` are set in any cycle.
- R6: The second instruction is granted only when the first is granted in that cycle, the second is valid and passes the same scoreboard test, and the two are independent. Independent means: if the first writes, neither source nor the destination of the second equals the first's destination; if the second writes, its destination equals neither source of the first.
- R7: The scan visits warps in ascending index order with wrap-around. It starts at the warp after the last warp granted in the most recent cycle that had any grant, and picks the first `ISSUE_SLOTS` warps that are ready.
- R8: When a writeback and a new issue name the same warp and register at the same edge, the bit ends up set.
- R9: Busy state is kept separately per warp. A register busy in one warp does not block another warp that uses the same register index.
- R10: A warp whose first instruction is invalid receives no grant, whatever its second instruction holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd0_valid | input | NUM_WARPS | First instruction of each warp present |
| hd0_wr | input | NUM_WARPS | First instruction writes a register |
| hd0_dst | input | NUM_WARPS*RW | First instruction destination index, warp w at bits [w*RW +: RW] |
| hd0_srca | input | NUM_WARPS*RW | First instruction source A index |
| hd0_srcb | input | NUM_WARPS*RW | First instruction source B index |
| hd1_valid | input | NUM_WARPS | Second instruction present |
| hd1_wr | input | NUM_WARPS | Second instruction writes a register |
| hd1_dst | input | NUM_WARPS*RW | Second instruction destination index |
| hd1_srca | input | NUM_WARPS*RW | Second instruction source A index |
| hd1_srcb | input | NUM_WARPS*RW | Second instruction source B index |
| wb_valid | input | WB_PORTS | Writeback notification valid, one per port |
| wb_warp | input | WB_PORTS*WW | Writeback warp index, port p at [p*WW +: WW] |
| wb_reg | input | WB_PORTS*RW | Writeback register index, port p at [p*RW +: RW] |
| grant_first | output | NUM_WARPS | First instruction of warp w started |
| grant_second | output | NUM_WARPS | Second instruction of warp w started as well |

## Verification
Every decision is due exactly one clock after the inputs that caused it. The bench drives descriptors and writebacks on the falling edge and compares both grant vectors on the next falling edge against a behavioural model. The model is advanced once per clock with the same inputs. A writeback clears a bit at the edge where it appears, so its effect on grants shows up one comparison later. A new issue's busy bit blocks a dependant at the very next decision. Directed sequences aim checks at the cycle where each of these effects must first show. A long random run then feeds writebacks back a fixed latency after each write issue.

// File: rtl/ws_pkg.sv
package ws_pkg;

  typedef struct packed {
    logic first;
    logic second;
  } issue_pair_t;

  function automatic int wrap_add(input int base, input int step, input int n);
    return (base + step) % n;
  endfunction

endpackage

// File: rtl/ws_scoreboard.sv
module ws_scoreboard #(
  parameter int NUM_WARPS = 16,
  parameter int NUM_REGS  = 16,
  parameter int WB_PORTS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_WARPS*NUM_REGS-1:0] set_mask,
  input  logic [WB_PORTS-1:0]           wb_valid,
  input  logic [WB_PORTS*$clog2(NUM_WARPS)-1:0] wb_warp,
  input  logic [WB_PORTS*$clog2(NUM_REGS)-1:0]  wb_reg,
  output logic [NUM_WARPS*NUM_REGS-1:0] busy
);
  localparam int WW   = $clog2(NUM_WARPS);
  localparam int RW   = $clog2(NUM_REGS);
  localparam int BITS = NUM_WARPS * NUM_REGS;

  logic [BITS-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    for (int p = 0; p < WB_PORTS; p++) begin
      if (wb_valid[p])
        clr_mask[int'(wb_warp[p*WW +: WW]) * NUM_REGS + int'(wb_reg[p*RW +: RW])] = 1'b1;
    end
  end

  // a fresh issue overrides a same-edge clear
  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~clr_mask) | set_mask;
  end

  p_set_survives_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(set_mask) & ~busy) == '0));

  p_clear_takes_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(clr_mask & ~set_mask) & busy) == '0));

endmodule

// File: rtl/ws_hazard_check.sv
module ws_hazard_check #(
  parameter int NUM_REGS = 16,
  parameter int RW       = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] busy_row,
  input  logic                a_valid,
  input  logic                a_wr,
  input  logic [RW-1:0]       a_dst,
  input  logic [RW-1:0]       a_srca,
  input  logic [RW-1:0]       a_srcb,
  input  logic                b_valid,
  input  logic                b_wr,
  input  logic [RW-1:0]       b_dst,
  input  logic [RW-1:0]       b_srca,
  input  logic [RW-1:0]       b_srcb,
  output logic                first_ok,
  output logic                pair_ok
);
  logic second_clear, raw_or_waw, war;

  always_comb begin
    first_ok     = a_valid && !busy_row[a_srca] && !busy_row[a_srcb]
                   && !(a_wr && busy_row[a_dst]);
    second_clear = b_valid && !busy_row[b_srca] && !busy_row[b_srcb]
                   && !(b_wr && busy_row[b_dst]);
    raw_or_waw   = a_wr && ((b_srca == a_dst) || (b_srcb == a_dst)
                   || (b_wr && (b_dst == a_dst)));
    war          = b_wr && ((b_dst == a_srca) || (b_dst == a_srcb));
    pair_ok      = first_ok && second_clear && !raw_or_waw && !war;
  end

endmodule

// File: rtl/ws_rr_select.sv
module ws_rr_select #(
  parameter int NUM_WARPS   = 16,
  parameter int ISSUE_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] ready,
  output logic [NUM_WARPS-1:0] pick
);
  import ws_pkg::*;
  localparam int PW = $clog2(NUM_WARPS);

  logic [PW-1:0] last_q, last_d;
  logic          any_pick;

  always_comb begin
    int cnt;
    int idx;
    cnt      = 0;
    pick     = '0;
    last_d   = last_q;
    any_pick = 1'b0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      idx = wrap_add(int'(last_q), k + 1, NUM_WARPS);
      if (ready[idx] && cnt < ISSUE_SLOTS) begin
        pick[idx] = 1'b1;
        cnt       = cnt + 1;
        last_d    = PW'(idx);
        any_pick  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           last_q <= PW'(NUM_WARPS - 1);
    else if (any_pick) last_q <= last_d;
  end

  p_pick_subset_r7: assert property (@(posedge clk) disable iff (rst)
    (pick & ~ready) == '0);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS   = 16,
  parameter int NUM_REGS    = 16,
  parameter int ISSUE_SLOTS = 4,
  parameter int WB_PORTS    = 4,
  parameter int WW          = $clog2(NUM_WARPS),
  parameter int RW          = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_WARPS-1:0]    hd0_valid,
  input  logic [NUM_WARPS-1:0]    hd0_wr,
  input  logic [NUM_WARPS*RW-1:0] hd0_dst,
  input  logic [NUM_WARPS*RW-1:0] hd0_srca,
  input  logic [NUM_WARPS*RW-1:0] hd0_srcb,
  input  logic [NUM_WARPS-1:0]    hd1_valid,
  input  logic [NUM_WARPS-1:0]    hd1_wr,
  input  logic [NUM_WARPS*RW-1:0] hd1_dst,
  input  logic [NUM_WARPS*RW-1:0] hd1_srca,
  input  logic [NUM_WARPS*RW-1:0] hd1_srcb,
  input  logic [WB_PORTS-1:0]     wb_valid,
  input  logic [WB_PORTS*WW-1:0]  wb_warp,
  input  logic [WB_PORTS*RW-1:0]  wb_reg,
  output logic [NUM_WARPS-1:0]    grant_first,
  output logic [NUM_WARPS-1:0]    grant_second
);
  import ws_pkg::*;
  localparam int BITS = NUM_WARPS * NUM_REGS;

  logic [BITS-1:0]      busy;
  logic [BITS-1:0]      set_mask;
  logic [NUM_WARPS-1:0] first_ok, pair_ok, pick0, pick1;
  issue_pair_t          grant_q [NUM_WARPS];

  ws_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .WB_PORTS(WB_PORTS)) u_sb (
    .clk(clk), .rst(rst), .set_mask(set_mask),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg), .busy(busy)
  );

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    ws_hazard_check #(.NUM_REGS(NUM_REGS), .RW(RW)) u_hz (
      .busy_row(busy[w*NUM_REGS +: NUM_REGS]),
      .a_valid(hd0_valid[w]), .a_wr(hd0_wr[w]), .a_dst(hd0_dst[w*RW +: RW]),
      .a_srca(hd0_srca[w*RW +: RW]), .a_srcb(hd0_srcb[w*RW +: RW]),
      .b_valid(hd1_valid[w]), .b_wr(hd1_wr[w]), .b_dst(hd1_dst[w*RW +: RW]),
      .b_srca(hd1_srca[w*RW +: RW]), .b_srcb(hd1_srcb[w*RW +: RW]),
      .first_ok(first_ok[w]), .pair_ok(pair_ok[w])
    );

    always_ff @(posedge clk) begin
      if (rst) grant_q[w] <= '0;
      else     grant_q[w] <= '{first: pick0[w], second: pick1[w]};
    end

    assign grant_first[w]  = grant_q[w].first;
    assign grant_second[w] = grant_q[w].second;
  end

  ws_rr_select #(.NUM_WARPS(NUM_WARPS), .ISSUE_SLOTS(ISSUE_SLOTS)) u_rr (
    .clk(clk), .rst(rst), .ready(first_ok), .pick(pick0)
  );

  assign pick1 = pick0 & pair_ok;

  always_comb begin
    set_mask = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (pick0[w] && hd0_wr[w])
        set_mask[w*NUM_REGS + int'(hd0_dst[w*RW +: RW])] = 1'b1;
      if (pick1[w] && hd1_wr[w])
        set_mask[w*NUM_REGS + int'(hd1_dst[w*RW +: RW])] = 1'b1;
    end
  end

  p_second_needs_first_r2: assert property (@(posedge clk) disable iff (rst)
    (grant_second & ~grant_first) == '0);

  p_slot_limit_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_first) <= ISSUE_SLOTS);

  p_grant_was_ready_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((grant_first & ~$past(first_ok)) == '0));

endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW  = 16;
  localparam int NR  = 16;
  localparam int SL  = 4;
  localparam int WB  = 4;
  localparam int WW  = $clog2(NW);
  localparam int RW  = $clog2(NR);
  localparam int LAT = 10;

  logic clk = 1'b0;
  logic rst;
  logic [NW-1:0]    hd0_valid, hd0_wr, hd1_valid, hd1_wr;
  logic [NW*RW-1:0] hd0_dst, hd0_srca, hd0_srcb, hd1_dst, hd1_srca, hd1_srcb;
  logic [WB-1:0]    wb_valid;
  logic [WB*WW-1:0] wb_warp;
  logic [WB*RW-1:0] wb_reg;
  logic [NW-1:0]    grant_first, grant_second;

  always #2 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .ISSUE_SLOTS(SL), .WB_PORTS(WB)) dut (
    .clk(clk), .rst(rst),
    .hd0_valid(hd0_valid), .hd0_wr(hd0_wr), .hd0_dst(hd0_dst), .hd0_srca(hd0_srca), .hd0_srcb(hd0_srcb),
    .hd1_valid(hd1_valid), .hd1_wr(hd1_wr), .hd1_dst(hd1_dst), .hd1_srca(hd1_srca), .hd1_srcb(hd1_srcb),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .grant_first(grant_first), .grant_second(grant_second)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          mb [NW][NR];
  int          mptr;
  logic [NW-1:0] e1, e2;

  typedef struct { int due; int w; int r; } pend_t;
  pend_t pend [$];

  task automatic chk(input string req, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  task automatic set_h0(input int w, input bit v, input bit wr, input int d, input int a, input int b);
    hd0_valid[w] = v; hd0_wr[w] = wr;
    hd0_dst[w*RW +: RW] = RW'(d); hd0_srca[w*RW +: RW] = RW'(a); hd0_srcb[w*RW +: RW] = RW'(b);
  endtask

  task automatic set_h1(input int w, input bit v, input bit wr, input int d, input int a, input int b);
    hd1_valid[w] = v; hd1_wr[w] = wr;
    hd1_dst[w*RW +: RW] = RW'(d); hd1_srca[w*RW +: RW] = RW'(a); hd1_srcb[w*RW +: RW] = RW'(b);
  endtask

  task automatic set_wb(input int p, input bit v, input int w, input int r);
    wb_valid[p] = v; wb_warp[p*WW +: WW] = WW'(w); wb_reg[p*RW +: RW] = RW'(r);
  endtask

  task automatic clear_inputs();
    hd0_valid = '0; hd0_wr = '0; hd0_dst = '0; hd0_srca = '0; hd0_srcb = '0;
    hd1_valid = '0; hd1_wr = '0; hd1_dst = '0; hd1_srca = '0; hd1_srcb = '0;
    wb_valid = '0; wb_warp = '0; wb_reg = '0;
  endtask

  // behavioural expectation for the inputs now driven, then advance the model
  task automatic predict();
    int cnt = 0;
    int last = mptr;
    e1 = '0; e2 = '0;
    for (int k = 0; k < NW; k++) begin
      int w = (mptr + 1 + k) % NW;
      int d0 = int'(hd0_dst[w*RW +: RW]), a0 = int'(hd0_srca[w*RW +: RW]), b0 = int'(hd0_srcb[w*RW +: RW]);
      int d1 = int'(hd1_dst[w*RW +: RW]), a1 = int'(hd1_srca[w*RW +: RW]), b1 = int'(hd1_srcb[w*RW +: RW]);
      bit ok0 = hd0_valid[w] && !mb[w][a0] && !mb[w][b0] && !(hd0_wr[w] && mb[w][d0]);
      bit ok1 = hd1_valid[w] && !mb[w][a1] && !mb[w][b1] && !(hd1_wr[w] && mb[w][d1]);
      bit dep = (hd0_wr[w] && (a1 == d0 || b1 == d0 || (hd1_wr[w] && d1 == d0)))
             || (hd1_wr[w] && (d1 == a0 || d1 == b0));
      if (ok0 && cnt < SL) begin
        e1[w] = 1'b1; cnt++; last = w;
        if (ok1 && !dep) e2[w] = 1'b1;
      end
    end
    for (int p = 0; p < WB; p++)
      if (wb_valid[p]) mb[int'(wb_warp[p*WW +: WW])][int'(wb_reg[p*RW +: RW])] = 1'b0;
    for (int w = 0; w < NW; w++) begin
      if (e1[w] && hd0_wr[w]) mb[w][int'(hd0_dst[w*RW +: RW])] = 1'b1;
      if (e2[w] && hd1_wr[w]) mb[w][int'(hd1_dst[w*RW +: RW])] = 1'b1;
    end
    if (cnt > 0) mptr = last;
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    chk("R3 first grants vs model (R2 R5 R7 R9 R10)", grant_first, e1);
    chk("R6 second grants vs model (R2 R4 R8)", grant_second, e2);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < NW; w++) for (int r = 0; r < NR; r++) mb[w][r] = 1'b0;
    mptr = NW - 1;
    pend.delete();
    chk("R1 first grants after reset", grant_first, '0);
    chk("R1 second grants after reset", grant_second, '0);
  endtask

  task automatic rand_h0(input int w);
    set_h0(w, ($urandom % 8) != 0, ($urandom % 4) != 0, $urandom % NR, $urandom % NR, $urandom % NR);
  endtask
  task automatic rand_h1(input int w);
    set_h1(w, ($urandom % 8) != 0, ($urandom % 4) != 0, $urandom % NR, $urandom % NR, $urandom % NR);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R7 R5: all 16 ready, four slots, scan from warp 0
    for (int w = 0; w < NW; w++) set_h0(w, 1, 1, 1, 2, 3);
    step();
    chk("R7 first window", grant_first, 16'h000F);
    // R3 WAW blocks warps 0-3, scan resumes at 4
    step();
    chk("R3 R7 second window", grant_first, 16'h00F0);

    // R8 R9 R4
    do_reset();
    set_h0(0, 1, 1, 5, 0, 0);
    set_wb(0, 1, 0, 5);
    step();
    chk("R8 issue alongside clear", grant_first, 16'h0001);
    set_wb(0, 0, 0, 0);
    set_h0(0, 1, 0, 0, 5, 5);
    set_h0(1, 1, 0, 0, 5, 5);
    step();
    chk("R8 R9 bit stays set, other warp free", grant_first, 16'h0002);
    set_wb(0, 1, 0, 5);
    step();
    chk("R4 clear not yet seen", grant_first & 16'h0001, 16'h0000);
    set_wb(0, 0, 0, 0);
    step();
    chk("R4 dependant after clear", grant_first & 16'h0001, 16'h0001);

    // R6 R10 pairing rules
    do_reset();
    set_h0(2, 1, 1, 4, 1, 1);  set_h1(2, 1, 0, 0, 4, 0);
    set_h0(3, 1, 1, 4, 1, 1);  set_h1(3, 1, 1, 6, 7, 8);
    set_h0(5, 1, 0, 0, 9, 10); set_h1(5, 1, 1, 9, 11, 12);
    set_h0(6, 0, 1, 3, 3, 3);  set_h1(6, 1, 0, 0, 1, 2);
    step();
    chk("R10 R6 first grants", grant_first, 16'h002C);
    chk("R6 only independent pair", grant_second, 16'h0008);

    // random run with writebacks returning LAT cycles after issue
    do_reset();
    for (int w = 0; w < NW; w++) begin rand_h0(w); rand_h1(w); end
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int n = 0;
      int i = 0;
      wb_valid = '0;
      while (i < pend.size()) begin
        if (pend[i].due <= cyc && n < WB) begin
          set_wb(n, 1, pend[i].w, pend[i].r);
          n++;
          pend.delete(i);
        end else i++;
      end
      step();
      for (int w = 0; w < NW; w++) begin
        if (e1[w] && hd0_wr[w]) pend.push_back('{cyc + LAT, w, int'(hd0_dst[w*RW +: RW])});
        if (e2[w] && hd1_wr[w]) pend.push_back('{cyc + LAT, w, int'(hd1_dst[w*RW +: RW])});
        if (e2[w]) begin
          rand_h0(w); rand_h1(w);
        end else if (e1[w]) begin
          set_h0(w, hd1_valid[w], hd1_wr[w], int'(hd1_dst[w*RW +: RW]),
                 int'(hd1_srca[w*RW +: RW]), int'(hd1_srcb[w*RW +: RW]));
          rand_h1(w);
        end else if (!hd0_valid[w]) begin
          rand_h0(w);
        end
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule